// File: doc/BRIEF.md
# Banked Scratchpad Conflict Arbiter

This block sits in front of an on-chip scratchpad built from 32 independent banks, each one 32-bit word wide. A warp-wide request carries 32 lanes. Each lane has an enable bit, a word address, a read/write select and write data. The block finds the bank each lane targets. Whenever two or more lanes need different words in the same bank, it splits the request into several passes. In every pass each bank serves no more than one word address.

Lanes that name the same word share a pass, and a read value is broadcast to all of them. When the final pass finishes, the block presents the read data for every lane at once. It also pulses a completion strobe and reports how many passes the request took. That count is the conflict degree, which a kernel author can use to check whether a tile layout runs without bank conflicts. While a request is in progress the block accepts no new one.

Top module: `sp_conflict_arbiter`

## Requirements
- R1: A lane's bank is the low 5 bits of its word address (word address modulo 32), and the row within that bank is the remaining upper bits. A request whose active lanes all land in distinct banks finishes in a single pass.
- R2: Active lanes that name different words in the same bank are served in separate passes. The degree reported for a request equals the largest number of distinct active word addresses found in any one bank.
- R3: Active lanes that read the same word are served in one pass, and each of them receives that word's stored value.
- R4: In each pass, the lowest-numbered pending lane claims its bank, and every pending lane with the same word address is served alongside it. For example, lanes 0, 1 and 2 on addresses A, B, A in one bank need exactly 2 passes.
- R5: When several active lanes write the same word in one request, the data of the highest-numbered of those lanes is what gets stored.
- R6: A lane that reads a word written by another lane of the same request gets the value the word held before that request.
- R7: The completion strobe is high for exactly one cycle. It rises exactly degree cycles after the edge that accepted the request. The degree lies between 1 and 32, and a request with no active lanes completes after 1 pass.
- R8: Read data for all lanes appears together with the completion strobe and stays unchanged until the next completion. Lanes that are inactive or that write return zero.
- R9: The ready output is high only while no request is in progress. A request presented while one is in progress is ignored and causes no memory change and no extra completion.
- R10: Inactive lanes never write, never occupy a bank and never add to the degree.
- R11: After reset, ready is 1, the completion strobe is 0, the degree is 0 and all read data is 0.
- R12: On a 32x32 word tile, walking a column with all 32 lanes needs 32 passes when the row pitch is 32 words. The same walk needs 1 pass when the pitch is padded to 33 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; taken on a clock edge where req_ready is high |
| req_ready | output | 1 | Block is idle and will take a request |
| req_active | input | LANES (32) | Per-lane enable |
| req_write | input | LANES (32) | Per-lane write select (1 = write, 0 = read) |
| req_addr | input | LANES*ADDR_W (352) | Per-lane word address, lane i at bits [i*ADDR_W +: ADDR_W] |
| req_wdata | input | LANES*DATA_W (1024) | Per-lane write data, lane i at bits [i*DATA_W +: DATA_W] |
| acc_done | output | 1 | One-cycle completion strobe |
| acc_degree | output | CNT_W (6) | Number of passes used by the finished request |
| acc_rdata | output | LANES*DATA_W (1024) | Per-lane read result, held until the next completion |

## Verification
On every cycle, the assertions check the following. Each pass in progress serves at least one lane. Only pending lanes are ever served. The pass counter never passes the lane count. The completion strobe is a single-cycle pulse carrying a degree between 1 and 32. Read data moves only at completion. Ready drops after an accepted request. Other behaviour is visible only through the bench's scenarios: the exact degree for a given address pattern, the grouping of a lane with the lane that won its bank, broadcast reads, which write wins on a shared word, read-before-write ordering inside one request, and the padded-versus-unpadded tile walk. The bench compares these against a shadow memory and a conflict-degree count of its own.

// File: rtl/sp_arb_pkg.sv
package sp_arb_pkg;

    // Phase of the request sequencer
    typedef enum logic [0:0] {
        SP_IDLE = 1'b0,
        SP_BUSY = 1'b1
    } sp_phase_e;

endpackage

// File: rtl/sp_pass_select.sv
// Picks, for one pass, the word each bank serves and the lanes served by it.
module sp_pass_select #(
    parameter int LANES  = 32,
    parameter int BANKS  = 32,
    parameter int ADDR_W = 11
) (
    input  logic [LANES-1:0]                         pending_i,
    input  logic [LANES*ADDR_W-1:0]                  addr_i,
    output logic [LANES-1:0]                         served_o,
    output logic [LANES*$clog2(BANKS)-1:0]           lane_bank_o,
    output logic [BANKS-1:0]                         bank_hit_o,
    output logic [BANKS*(ADDR_W-$clog2(BANKS))-1:0]  bank_row_o
);
    localparam int BANK_W = $clog2(BANKS);
    localparam int ROW_W  = ADDR_W - BANK_W;

    logic [ADDR_W-1:0] lane_addr [LANES];
    logic [BANK_W-1:0] lane_bank [LANES];
    logic [LANES-1:0]  leader;
    logic [ADDR_W-1:0] bank_word [BANKS];

    // Split each lane address into bank (low bits) and row (high bits)
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            lane_addr[i] = addr_i[i*ADDR_W +: ADDR_W];
            lane_bank[i] = lane_addr[i][BANK_W-1:0];
            lane_bank_o[i*BANK_W +: BANK_W] = lane_bank[i];
        end
    end

    // A lane leads its bank when no lower pending lane targets that bank
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            leader[i] = pending_i[i];
            for (int j = 0; j < i; j++) begin
                if (pending_i[j] && (lane_bank[j] == lane_bank[i])) begin
                    leader[i] = 1'b0;
                end
            end
        end
    end

    // Each bank takes the word of its leader
    always_comb begin
        for (int b = 0; b < BANKS; b++) begin
            bank_word[b]  = '0;
            bank_hit_o[b] = 1'b0;
            for (int i = 0; i < LANES; i++) begin
                if (leader[i] && (lane_bank[i] == BANK_W'(b))) begin
                    bank_word[b]  = lane_addr[i];
                    bank_hit_o[b] = 1'b1;
                end
            end
            bank_row_o[b*ROW_W +: ROW_W] = bank_word[b][ADDR_W-1:BANK_W];
        end
    end

    // Every pending lane on its bank's chosen word rides along in this pass
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            served_o[i] = pending_i[i] && (lane_addr[i] == bank_word[lane_bank[i]]);
        end
    end

endmodule

// File: rtl/sp_bank_array.sv
// The banked storage: one word read and at most one word written per bank per cycle.
module sp_bank_array #(
    parameter int LANES      = 32,
    parameter int BANKS      = 32,
    parameter int BANK_DEPTH = 64,
    parameter int DATA_W     = 32
) (
    input  logic                                 clk_i,
    input  logic [LANES-1:0]                     served_i,
    input  logic [LANES*$clog2(BANKS)-1:0]       lane_bank_i,
    input  logic [LANES-1:0]                     write_i,
    input  logic [LANES*DATA_W-1:0]              wdata_i,
    input  logic [BANKS-1:0]                     bank_hit_i,
    input  logic [BANKS*$clog2(BANK_DEPTH)-1:0]  bank_row_i,
    output logic [LANES*DATA_W-1:0]              lane_rdata_o
);
    localparam int BANK_W = $clog2(BANKS);
    localparam int ROW_W  = $clog2(BANK_DEPTH);

    logic [BANKS*DATA_W-1:0] bank_rd;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [DATA_W-1:0] mem_q [BANK_DEPTH];
        logic [ROW_W-1:0]  row;
        logic              we;
        logic [DATA_W-1:0] wd;

        assign row = bank_row_i[b*ROW_W +: ROW_W];

        // Ascending scan: the highest served writing lane on this bank wins
        always_comb begin
            we = 1'b0;
            wd = '0;
            for (int i = 0; i < LANES; i++) begin
                if (served_i[i] && write_i[i] &&
                    (lane_bank_i[i*BANK_W +: BANK_W] == BANK_W'(b))) begin
                    we = bank_hit_i[b];
                    wd = wdata_i[i*DATA_W +: DATA_W];
                end
            end
        end

        always_ff @(posedge clk_i) begin
            if (we) begin
                mem_q[row] <= wd;
            end
        end

        // Read is the value before this cycle's write
        assign bank_rd[b*DATA_W +: DATA_W] = mem_q[row];
    end

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            lane_rdata_o[i*DATA_W +: DATA_W] =
                bank_rd[int'(lane_bank_i[i*BANK_W +: BANK_W])*DATA_W +: DATA_W];
        end
    end

endmodule

// File: rtl/sp_conflict_arbiter.sv
module sp_conflict_arbiter
    import sp_arb_pkg::*;
#(
    parameter int  LANES      = 32,
    parameter int  BANKS      = 32,
    parameter int  BANK_DEPTH = 64,
    parameter int  DATA_W     = 32,
    localparam int ADDR_W     = $clog2(BANKS) + $clog2(BANK_DEPTH),
    localparam int CNT_W      = $clog2(LANES) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [LANES-1:0]         req_active,
    input  logic [LANES-1:0]         req_write,
    input  logic [LANES*ADDR_W-1:0]  req_addr,
    input  logic [LANES*DATA_W-1:0]  req_wdata,
    output logic                     acc_done,
    output logic [CNT_W-1:0]         acc_degree,
    output logic [LANES*DATA_W-1:0]  acc_rdata
);
    localparam int BANK_W = $clog2(BANKS);
    localparam int ROW_W  = $clog2(BANK_DEPTH);

    typedef struct packed {
        sp_phase_e                 phase;
        logic [LANES-1:0]          pend;
        logic [LANES-1:0]          wr;
        logic [LANES*ADDR_W-1:0]   addr;
        logic [LANES*DATA_W-1:0]   wdata;
        logic [LANES*DATA_W-1:0]   cap;
        logic [LANES*DATA_W-1:0]   rdata;
        logic [CNT_W-1:0]          cnt;
        logic                      done;
        logic [CNT_W-1:0]          degree;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [LANES-1:0]         served;
    logic [LANES*BANK_W-1:0]  lane_bank;
    logic [BANKS-1:0]         bank_hit;
    logic [BANKS*ROW_W-1:0]   bank_row;
    logic [LANES*DATA_W-1:0]  lane_rdata;

    sp_pass_select #(
        .LANES  (LANES),
        .BANKS  (BANKS),
        .ADDR_W (ADDR_W)
    ) u_select (
        .pending_i   (st_q.pend),
        .addr_i      (st_q.addr),
        .served_o    (served),
        .lane_bank_o (lane_bank),
        .bank_hit_o  (bank_hit),
        .bank_row_o  (bank_row)
    );

    sp_bank_array #(
        .LANES      (LANES),
        .BANKS      (BANKS),
        .BANK_DEPTH (BANK_DEPTH),
        .DATA_W     (DATA_W)
    ) u_banks (
        .clk_i        (clk),
        .served_i     (served),
        .lane_bank_i  (lane_bank),
        .write_i      (st_q.wr),
        .wdata_i      (st_q.wdata),
        .bank_hit_i   (bank_hit),
        .bank_row_i   (bank_row),
        .lane_rdata_o (lane_rdata)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            SP_IDLE: begin
                if (req_valid) begin
                    st_d.phase = SP_BUSY;
                    st_d.pend  = req_active;
                    st_d.wr    = req_write;
                    st_d.addr  = req_addr;
                    st_d.wdata = req_wdata;
                    st_d.cap   = '0;
                    st_d.cnt   = '0;
                end
            end
            SP_BUSY: begin
                st_d.pend = st_q.pend & ~served;
                for (int i = 0; i < LANES; i++) begin
                    if (served[i] && !st_q.wr[i]) begin
                        st_d.cap[i*DATA_W +: DATA_W] = lane_rdata[i*DATA_W +: DATA_W];
                    end
                end
                st_d.cnt = st_q.cnt + CNT_W'(1);
                if (st_d.pend == '0) begin
                    st_d.phase  = SP_IDLE;
                    st_d.done   = 1'b1;
                    st_d.degree = st_d.cnt;
                    st_d.rdata  = st_d.cap;
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready  = (st_q.phase == SP_IDLE);
    assign acc_done   = st_q.done;
    assign acc_degree = st_q.degree;
    assign acc_rdata  = st_q.rdata;

    // Each pass in progress must retire at least one pending lane
    assert_pass_progress_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == SP_BUSY && st_q.pend != '0) |-> (served != '0));

    // The selector never serves a lane that is not pending (inactive lanes stay out)
    assert_served_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((served & ~st_q.pend) == '0));

    // Pass counter stays within the lane count while in progress
    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == SP_BUSY) |-> (int'(st_q.cnt) < LANES));

    assert_degree_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |-> (acc_degree >= CNT_W'(1) && int'(acc_degree) <= LANES));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |=> !acc_done);

    assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_done |-> $stable(acc_rdata));

    assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> !req_ready);

endmodule

// File: tb/tb_sp_conflict_arbiter.sv
module tb_sp_conflict_arbiter;

    localparam int LANES      = 32;
    localparam int BANKS      = 32;
    localparam int BANK_DEPTH = 64;
    localparam int DATA_W     = 32;
    localparam int BANK_W     = $clog2(BANKS);
    localparam int AW         = $clog2(BANKS) + $clog2(BANK_DEPTH);
    localparam int CNT_W      = $clog2(LANES) + 1;
    localparam int WORDS      = BANKS * BANK_DEPTH;

    // Read vectors: lane i reads word (base + i*stride) mod WORDS
    localparam int NVEC = 9;
    localparam int TBL_STRIDE [NVEC] = '{1, 32, 33, 2, 0, 16, 64, 4, 17};
    localparam int TBL_BASE   [NVEC] = '{0,  5,  0, 0, 100, 3,  0, 7, 9};
    localparam int TBL_DEG    [NVEC] = '{1, 32,  1, 2, 1, 16, 32, 4, 1};

    logic                     clk;
    logic                     rst_n;
    logic                     req_valid;
    logic                     req_ready;
    logic [LANES-1:0]         req_active;
    logic [LANES-1:0]         req_write;
    logic [LANES*AW-1:0]      req_addr;
    logic [LANES*DATA_W-1:0]  req_wdata;
    logic                     acc_done;
    logic [CNT_W-1:0]         acc_degree;
    logic [LANES*DATA_W-1:0]  acc_rdata;

    sp_conflict_arbiter #(
        .LANES      (LANES),
        .BANKS      (BANKS),
        .BANK_DEPTH (BANK_DEPTH),
        .DATA_W     (DATA_W)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_active (req_active),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .acc_done   (acc_done),
        .acc_degree (acc_degree),
        .acc_rdata  (acc_rdata)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    int checks   = 0;
    int failures = 0;

    logic [31:0]      shadow [WORDS];
    logic [LANES-1:0] st_act;
    logic [LANES-1:0] st_wr;
    logic [AW-1:0]    st_addr [LANES];
    logic [31:0]      st_wd   [LANES];

    int          exp_deg;
    logic [31:0] exp_rd [LANES];
    int          got_deg;
    int          got_cycles;
    int          got_extra_done;
    logic [LANES*DATA_W-1:0] saved_rd;

    function automatic logic [31:0] pat(input int a);
        return (32'(a) * 32'h0100_0193) ^ 32'h5A5A_0000;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic clear_st();
        st_act = '0;
        st_wr  = '0;
        for (int i = 0; i < LANES; i++) begin
            st_addr[i] = '0;
            st_wd[i]   = '0;
        end
    endtask

    task automatic fill_stride(input int base, input int stride, input bit wr);
        for (int i = 0; i < LANES; i++) begin
            st_act[i]  = 1'b1;
            st_wr[i]   = wr;
            st_addr[i] = AW'((base + i * stride) % WORDS);
            st_wd[i]   = pat((base + i * stride) % WORDS);
        end
    endtask

    // Model: degree = most distinct active words in one bank; reads before writes
    task automatic model();
        exp_deg = 0;
        for (int b = 0; b < BANKS; b++) begin
            int n;
            n = 0;
            for (int i = 0; i < LANES; i++) begin
                if (st_act[i] && int'(st_addr[i][BANK_W-1:0]) == b) begin
                    bit dup;
                    dup = 1'b0;
                    for (int j = 0; j < i; j++) begin
                        if (st_act[j] && st_addr[j] == st_addr[i]) dup = 1'b1;
                    end
                    if (!dup) n++;
                end
            end
            if (n > exp_deg) exp_deg = n;
        end
        if (exp_deg == 0) exp_deg = 1;
        for (int i = 0; i < LANES; i++) begin
            exp_rd[i] = (st_act[i] && !st_wr[i]) ? shadow[st_addr[i]] : 32'h0;
        end
        for (int i = 0; i < LANES; i++) begin
            if (st_act[i] && st_wr[i]) shadow[st_addr[i]] = st_wd[i];
        end
    endtask

    task automatic launch(input bit junk);
        model();
        @(negedge clk);
        req_active = st_act;
        req_write  = st_wr;
        for (int i = 0; i < LANES; i++) begin
            req_addr[i*AW +: AW]         = st_addr[i];
            req_wdata[i*DATA_W +: DATA_W] = st_wd[i];
        end
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        if (junk) begin
            req_active = '1;
            req_write  = '1;
            for (int i = 0; i < LANES; i++) begin
                req_addr[i*AW +: AW]         = AW'(i);
                req_wdata[i*DATA_W +: DATA_W] = 32'hDEAD_BEEF;
            end
        end else begin
            req_valid = 1'b0;
        end
        got_cycles = 0;
        while (!acc_done && got_cycles < 100) begin
            @(negedge clk);
            got_cycles++;
        end
        req_valid = 1'b0;
        got_deg = int'(acc_degree);
        if (got_cycles >= 100) check(1'b0, "R7 completion timeout", got_cycles, exp_deg);
    endtask

    task automatic check_rd(input string tag);
        int bad;
        bad = -1;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (acc_rdata[i*DATA_W +: DATA_W] !== exp_rd[i]) bad = i;
        end
        if (bad < 0) check(1'b1, tag, 0, 0);
        else check(1'b0, tag, acc_rdata[bad*DATA_W +: DATA_W], exp_rd[bad]);
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        req_valid  = 1'b0;
        req_active = '0;
        req_write  = '0;
        req_addr   = '0;
        req_wdata  = '0;
        for (int a = 0; a < WORDS; a++) shadow[a] = 32'h0;
        clear_st();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        check(req_ready === 1'b1, "R11 ready after reset", req_ready, 1);
        check(acc_done === 1'b0, "R11 done after reset", acc_done, 0);
        check(acc_degree === '0, "R11 degree after reset", acc_degree, 0);
        check(acc_rdata === '0, "R11 rdata after reset", 0, 0);

        // Preload every word with a known pattern (R1: contiguous writes take one pass)
        for (int k = 0; k < WORDS / LANES; k++) begin
            clear_st();
            fill_stride(k * LANES, 1, 1'b1);
            launch(1'b0);
            if (k == 0) check(got_deg == 1, "R1 contiguous write degree", got_deg, 1);
        end

        // Vector table of strided reads
        for (int v = 0; v < NVEC; v++) begin
            clear_st();
            fill_stride(TBL_BASE[v], TBL_STRIDE[v], 1'b0);
            launch(1'b0);
            check(got_deg == TBL_DEG[v], "R2 table degree", got_deg, TBL_DEG[v]);
            check(got_deg == exp_deg, "R2 model degree", got_deg, exp_deg);
            check(got_cycles == TBL_DEG[v], "R7 latency equals degree", got_cycles, TBL_DEG[v]);
            check_rd("R3 table read data");
            if (TBL_STRIDE[v] == 32) check(got_deg == 32, "R12 pitch 32 column walk", got_deg, 32);
            if (TBL_STRIDE[v] == 33) check(got_deg == 1, "R12 pitch 33 column walk", got_deg, 1);
            if (TBL_STRIDE[v] == 0)  check(got_deg == 1, "R3 broadcast single pass", got_deg, 1);
        end

        // R4: lanes 0,1,2 on words 64,96,64 (all bank 0) need two passes
        clear_st();
        st_act[0] = 1'b1; st_addr[0] = AW'(64);
        st_act[1] = 1'b1; st_addr[1] = AW'(96);
        st_act[2] = 1'b1; st_addr[2] = AW'(64);
        launch(1'b0);
        check(got_deg == 2, "R4 leader grouping degree", got_deg, 2);
        check_rd("R4 grouped read data");

        // R5: lanes 3, 7, 20 write word 200; lane 20 data survives
        clear_st();
        st_act[3]  = 1'b1; st_wr[3]  = 1'b1; st_addr[3]  = AW'(200); st_wd[3]  = 32'h1111_0003;
        st_act[7]  = 1'b1; st_wr[7]  = 1'b1; st_addr[7]  = AW'(200); st_wd[7]  = 32'h1111_0007;
        st_act[20] = 1'b1; st_wr[20] = 1'b1; st_addr[20] = AW'(200); st_wd[20] = 32'h1111_0014;
        launch(1'b0);
        check(got_deg == 1, "R5 same-word writes degree", got_deg, 1);
        clear_st();
        st_act[0] = 1'b1; st_addr[0] = AW'(200);
        launch(1'b0);
        check(acc_rdata[31:0] === 32'h1111_0014, "R5 highest lane write wins", acc_rdata[31:0], 32'h1111_0014);

        // R6 / R8: lane 0 reads word 300 while lane 5 writes it
        clear_st();
        st_act[0] = 1'b1; st_addr[0] = AW'(300);
        st_act[5] = 1'b1; st_wr[5] = 1'b1; st_addr[5] = AW'(300); st_wd[5] = 32'hCAFE_0300;
        launch(1'b0);
        check(acc_rdata[31:0] === pat(300), "R6 read sees old value", acc_rdata[31:0], pat(300));
        check(acc_rdata[5*DATA_W +: DATA_W] === 32'h0, "R8 write lane reads zero",
              acc_rdata[5*DATA_W +: DATA_W], 0);
        clear_st();
        st_act[0] = 1'b1; st_addr[0] = AW'(300);
        launch(1'b0);
        check(acc_rdata[31:0] === 32'hCAFE_0300, "R6 write lands afterwards", acc_rdata[31:0], 32'hCAFE_0300);

        // R10: only lane 0 active; inactive lanes carry conflicting writes
        clear_st();
        st_act[0] = 1'b1; st_addr[0] = AW'(10);
        for (int i = 1; i < LANES; i++) begin
            st_wr[i]   = 1'b1;
            st_addr[i] = AW'(10 + 32 * i);
            st_wd[i]   = 32'hBAD0_0000 | 32'(i);
        end
        launch(1'b0);
        check(got_deg == 1, "R10 inactive lanes add no passes", got_deg, 1);
        check_rd("R10 inactive lanes read zero");
        clear_st();
        fill_stride(10, 32, 1'b0);
        launch(1'b0);
        check_rd("R10 inactive writes left memory intact");

        // R8: output held after completion
        saved_rd = acc_rdata;
        got_extra_done = 0;
        repeat (5) begin
            @(negedge clk);
            if (acc_done) got_extra_done++;
        end
        check(acc_rdata === saved_rd, "R8 rdata held between completions", 0, 0);
        check(got_extra_done == 0, "R7 single done pulse", got_extra_done, 0);

        // R9: junk request held valid during a 32-pass access
        clear_st();
        fill_stride(5, 32, 1'b0);
        launch(1'b1);
        check(got_deg == 32, "R9 in-flight access degree kept", got_deg, 32);
        check_rd("R9 in-flight read data kept");
        got_extra_done = 0;
        repeat (4) begin
            @(negedge clk);
            if (acc_done) got_extra_done++;
        end
        check(got_extra_done == 0, "R9 no completion for ignored request", got_extra_done, 0);
        check(req_ready === 1'b1, "R9 ready when idle", req_ready, 1);
        clear_st();
        fill_stride(0, 1, 1'b0);
        launch(1'b0);
        check_rd("R9 ignored request wrote nothing");

        // R7: empty request finishes in one pass
        clear_st();
        launch(1'b0);
        check(got_deg == 1, "R7 empty request degree", got_deg, 1);
        check(got_cycles == 1, "R7 empty request latency", got_cycles, 1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule